// File: doc/BRIEF.md
# Programmable Window Frequency Meter

This block compares an unknown clock, typically a free-running ring oscillator, against a known reference clock. Software programs a window length in cycles of the monitored clock, turns on the monitored-clock gate, and then sets the enable. The block counts reference-clock cycles from the moment the enable rises until the monitored-clock window has closed. At that point it freezes the count into a result register and raises a valid flag, which software polls.

All control inputs and both outputs live in the reference-clock domain. The monitored-clock side holds only a short synchronizer for the start condition, the window counter and a done flag. The done flag returns to the reference domain through a two-flop synchronizer with rising-edge detection. Clearing the enable drops valid, the result and the running count, so the next measurement starts from zero. If the monitored clock is dead, valid never rises and the internal count stops at its maximum value instead of wrapping. The enable should stay low for a few cycles of both clocks before it is set again.

Top module: `wfreq_meter`

## Requirements
- R1: After reset, `valid` is 0 and `result` is 0.
- R2: While `meas_en` is high and `valid` is low, the internal count advances by one on each reference clock. When `valid` rises, `result` equals the number of reference edges that were counted from the rise of `meas_en` up to, but not including, the edge that sets `valid`.
- R3: The window spans `win_len` monitored-clock cycles. `valid` cannot rise before `win_len` monitored edges have occurred since `meas_en` rose. The latched count lies between `win_len*Tmon/Tref - 1` and `(win_len+4)*Tmon/Tref + 6`.
- R4: While `meas_en` stays high, `valid` stays high once set and `result` does not change.
- R5: The clock edge after `meas_en` is sampled low leaves `valid` at 0 and `result` at 0.
- R6: While `frun_en` is low, the monitored-clock logic does not advance and `valid` stays low, even with `meas_en` high.
- R7: The internal count saturates at 2^CNT_W-1. A window that closes after that point reports `result` = 2^CNT_W-1.
- R8: A `win_len` of 0 behaves like a window of one monitored cycle.
- R9: A measurement that starts after the enable has been cleared begins counting from zero, independent of the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all control and outputs are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_mon | input | 1 | Clock under measurement |
| meas_en | input | 1 | Starts a measurement when set; clears the meter when low |
| frun_en | input | 1 | Monitored-clock gate; must be high before and during a measurement |
| win_len | input | WIN_W (24) | Window length in monitored-clock cycles |
| valid | output | 1 | Measurement complete |
| result | output | CNT_W (32) | Latched reference-cycle count |

## Verification
The window is measured with the monitored clock slower than the reference (34 ns and 62 ns periods), faster than it (10 ns and 18 ns periods), and at the 1024-cycle default window. Together these show that the window length is counted on the monitored side and not derived from the reference. A zero window separates the one-cycle minimum from an immediate or missing completion. A stopped monitored clock followed by a restart shows saturation against wrap-around. A run with the gate held off shows that the enable alone does not start the window. Back-to-back runs with different ratios show that each count starts from zero.

// File: rtl/wfreq_meter.sv
module wfreq_meter #(
  parameter int WIN_W = 24,
  parameter int CNT_W = 32
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             clk_mon,
  input  logic             meas_en,
  input  logic             frun_en,
  input  logic [WIN_W-1:0] win_len,
  output logic             valid,
  output logic [CNT_W-1:0] result
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             arm_q;
  logic [1:0]       arm_sync;
  logic             run_m;
  logic [WIN_W-1:0] mon_cnt;
  logic [WIN_W-1:0] mon_nxt;
  logic             done_m;
  logic [2:0]       done_s;
  logic             done_rise;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= meas_en & frun_en;

  always_ff @(posedge clk_mon or negedge rst_n)
    if (!rst_n) arm_sync <= '0;
    else        arm_sync <= {arm_sync[0], arm_q};

  assign run_m   = arm_sync[1];
  assign mon_nxt = mon_cnt + 1'b1;

  always_ff @(posedge clk_mon or negedge rst_n)
    if (!rst_n) begin
      mon_cnt <= '0;
      done_m  <= 1'b0;
    end else if (!run_m) begin
      mon_cnt <= '0;
      done_m  <= 1'b0;
    end else if (!done_m) begin
      mon_cnt <= mon_nxt;
      done_m  <= (mon_nxt >= win_len);
    end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) done_s <= '0;
    else        done_s <= {done_s[1:0], done_m};

  assign done_rise = done_s[1] & ~done_s[2];

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n)                         cnt_q <= '0;
    else if (!meas_en)                  cnt_q <= '0;
    else if (!valid && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      valid  <= 1'b0;
      result <= '0;
    end else if (!meas_en) begin
      valid  <= 1'b0;
      result <= '0;
    end else if (done_rise && !valid) begin
      valid  <= 1'b1;
      result <= cnt_q;
    end

endmodule

// File: rtl/wfreq_meter_chk.sv
module wfreq_meter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             meas_en,
  input logic             valid,
  input logic [CNT_W-1:0] result,
  input logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1
  always_comb if (!rst_n) reset_state_chk: assert (!valid && result == '0);

  // R2
  count_step_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (meas_en && !valid && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  valid_needs_en_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(valid) |-> $past(meas_en));

  // R4
  valid_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (meas_en && $past(valid && meas_en)) |-> (valid && $stable(result)));

  // R5
  clear_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !meas_en |=> (!valid && result == '0));

  // R7
  no_wrap_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0));

endmodule

bind wfreq_meter wfreq_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_ref(clk_ref),
  .rst_n  (rst_n),
  .meas_en(meas_en),
  .valid  (valid),
  .result (result),
  .cnt_q  (cnt_q)
);

// File: tb/sim_wfreq_meter.sv
`timescale 1ns/1ps
module sim_wfreq_meter;
  localparam int WIN_W = 24;
  localparam int CNT_W = 16;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk_ref = 0, clk_mon = 0, rst_n = 0;
  logic meas_en = 0, frun_en = 0;
  logic [WIN_W-1:0] win_len = '0;
  logic valid;
  logic [CNT_W-1:0] result;

  int total = 0, bad = 0, cyc = 0;
  int mon_half = 17;
  bit mon_on = 1, finished = 0;

  int m_cnt = 0, m_pre = 0, held = 0, mon_edges = 0, edges_at_valid = 0;
  bit en_at_edge = 0, valid_seen = 0;
  int err_cnt = 0, err_hold = 0, err_clr = 0;

  wfreq_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .clk_mon(clk_mon), .meas_en(meas_en),
    .frun_en(frun_en), .win_len(win_len), .valid(valid), .result(result));

  always #10 clk_ref = ~clk_ref;
  initial forever begin
    #(mon_half * 1ns);
    if (mon_on) clk_mon = ~clk_mon;
  end

  always @(posedge clk_mon)
    if (meas_en && frun_en) mon_edges++;
    else mon_edges = 0;

  always @(posedge clk_ref) begin
    en_at_edge = meas_en;
    if (!rst_n || !meas_en) begin
      m_cnt = 0; m_pre = 0;
    end else if (!valid) begin
      m_pre = m_cnt;
      if (m_cnt < MAXV) m_cnt++;
    end
  end

  always @(negedge clk_ref) if (rst_n) begin
    if (!en_at_edge) begin
      if (valid || result != 0) err_clr++;
      valid_seen = 0;
    end else if (valid) begin
      if (!valid_seen) begin
        valid_seen = 1; held = m_pre; edges_at_valid = mon_edges;
      end
      if (result != held) err_hold++;
    end else if (result != 0) err_cnt++;
  end

  task automatic chk(bit ok, string msg, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  always @(posedge clk_ref) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic measure(string tag, int n, int half);
    int eff = (n == 0) ? 1 : n;
    real tm = 2.0 * half;
    int lo = int'($floor(eff * tm / 20.0)) - 1;
    int hi = int'($ceil((eff + 4) * tm / 20.0)) + 6;
    int lim = hi + 100;
    mon_half = half;
    @(negedge clk_ref); frun_en = 1; win_len = n[WIN_W-1:0];
    repeat (4) @(negedge clk_ref);
    err_cnt = 0; err_hold = 0;
    meas_en = 1;
    for (int i = 0; i < lim && !valid_seen; i++) @(negedge clk_ref);
    chk(valid_seen, {tag, " R3 window closes"}, valid_seen, 1);
    chk(edges_at_valid >= eff, {tag, " R3 mon edges before valid"}, edges_at_valid, eff);
    chk(held >= lo && held <= hi, {tag, " R3 count in bounds"}, held, lo);
    repeat (20) @(negedge clk_ref);
    chk(err_cnt == 0, {tag, " R2 result zero while counting"}, err_cnt, 0);
    chk(err_hold == 0 && result == held[CNT_W-1:0], {tag, " R2 R4 latched count held"}, result, held);
    meas_en = 0;
    @(negedge clk_ref); @(negedge clk_ref);
    chk(!valid && result == 0, {tag, " R5 clear on disable"}, {valid, result}, 0);
    repeat (30) @(negedge clk_ref);
    frun_en = 0;
    repeat (4) @(negedge clk_ref);
  endtask

  initial begin
    repeat (3) @(negedge clk_ref);
    chk(!valid && result == 0, "R1 reset state", {valid, result}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk_ref);
    chk(!valid && result == 0, "R1 idle after reset", {valid, result}, 0);

    measure("default1024", 1024, 17);
    measure("fast_mon R9", 100, 5);
    measure("slow_mon R9", 300, 31);
    measure("zero_win R8", 0, 13);
    measure("long_win", 3000, 9);

    err_clr = 0;
    mon_half = 7; frun_en = 0; win_len = 50;
    @(negedge clk_ref); meas_en = 1;
    repeat (400) @(negedge clk_ref);
    chk(!valid && !valid_seen, "R6 no window without gate", valid, 0);
    meas_en = 0;
    repeat (20) @(negedge clk_ref);

    mon_on = 0; frun_en = 1; win_len = 16;
    repeat (4) @(negedge clk_ref);
    meas_en = 1;
    repeat (MAXV + 200) @(negedge clk_ref);
    chk(!valid, "R7 no valid with dead clock", valid, 0);
    mon_on = 1;
    for (int i = 0; i < 300 && !valid_seen; i++) @(negedge clk_ref);
    repeat (2) @(negedge clk_ref);
    chk(valid && result == MAXV, "R7 saturated count", result, MAXV);
    meas_en = 0;
    repeat (4) @(negedge clk_ref);
    chk(err_clr == 0, "R5 clear held every cycle", err_clr, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule